// File: doc/BRIEF.md
# Memory-to-Coprocessor Burst Sequencer

This block is a host-side bus sequencer. It moves a block of 32-bit words from memory into coprocessor registers over a shared, multiplexed address/data bus. A start request latches an instruction word, and the block then runs a fixed sequence of bus cycles. A command cycle puts the instruction fields and the coprocessor status on the bus. An address cycle puts the first word address on the bus, again with the status. After that comes one data cycle per word. During the data cycles the block releases the bus so that memory can drive the words straight to the coprocessor.

Each bus cycle lasts four clock phases. The instruction picks the word count from one of two sources: an immediate field, or a general register in the host register file. The instruction also names an index register that holds the bit address of the transfer. The index moves by 32 per word, either upward after each word or downward before each word. The final index is written back through the register-file port in the same cycle as a one-cycle completion pulse.

Top module: `copro_burst_seq`

## Requirements
- R1: After reset the block is idle: `done`, `bus_oe`, `alatch` and `data_cyc` are all low.
- R2: A start request accepted while idle begins a command cycle of four phases with `bus_oe` high and `alatch` high. The bus carries `{instr[31:5], cp_status}`. The instruction fields are: coprocessor ID `instr[7:5]`, immediate count `instr[12:8]`, count source `instr[13]`, index mode `instr[14]`, index register `instr[18:15]`, count register `instr[22:19]`.
- R3: An address cycle of four phases follows, with `bus_oe` and `alatch` high. The bus carries `{A[31:5], cp_status}`, where A is the address of the first word: the index value in up mode, or the index minus 32 in down mode.
- R4: One data cycle of four phases follows per word. `data_cyc` is high and `bus_oe` and `alatch` are low throughout, and the number of completed data cycles equals the word count.
- R5: When `instr[13]` is 0, the word count is `instr[12:8]`, and a value of 0 means 32 words.
- R6: When `instr[13]` is 1, the word count is the content of the register selected by `instr[22:19]`. A count of 0 skips the address and data cycles: done follows the command cycle, and the index is written back unchanged.
- R7: When `instr[14]` is 0 the index rises by 32 after each word. When it is 1 the index falls by 32 before each word. The final index (index ± 32·N) is written to the register selected by `instr[18:15]`.
- R8: While `ready` is low at phase 3 of a data cycle, that phase is held and the word is not counted.
- R9: `done` is a single-cycle pulse that coincides with the index write-back. With no stalls it is high in the 9+4N-th cycle after the cycle in which start was sampled.
- R10: A start request during a burst is ignored: the running burst keeps its word count, and no second burst follows it.
- R11: `full_width` is high at all times, since every cycle is a 32-bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst request, sampled while idle |
| instr | input | 32 | Instruction word latched with the start request |
| cp_status | input | 5 | Coprocessor status code placed on the bus in the command and address cycles |
| rf_raddr | output | 4 | Register-file read select |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Index write-back enable |
| rf_waddr | output | 4 | Index write-back register |
| rf_wdata | output | 32 | Final index value |
| bus_out | output | 32 | Value driven onto the multiplexed bus |
| bus_oe | output | 1 | Bus drive enable |
| alatch | output | 1 | Address-latch strobe |
| phase | output | 2 | Current phase within the bus cycle |
| data_cyc | output | 1 | High during data-transfer cycles |
| ready | input | 1 | Memory ready; low holds phase 3 of a data cycle |
| full_width | output | 1 | 32-bit bus-width indication |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sequencer is driven with an immediate count in up mode and the immediate code 0. These two runs separate a literal decode from the 32-word case. A register count in down mode tests both the count-source select and the decrement-before-word address shown in the address cycle. A register count of zero shows whether the address and data cycles are skipped and whether the index is left untouched. A run with `ready` toggling separates held phases from counted words, and a start pulse in the middle of a burst shows whether a busy request can restart or lengthen the burst.

// File: rtl/copro_burst_seq.sv
module copro_burst_seq #(
  parameter int DW   = 32,
  parameter int RSW  = 4,
  parameter int STW  = 5,
  parameter int STEP = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  instr,
  input  logic [STW-1:0] cp_status,
  output logic [RSW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RSW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic [DW-1:0]  bus_out,
  output logic           bus_oe,
  output logic           alatch,
  output logic [1:0]     phase,
  output logic           data_cyc,
  input  logic           ready,
  output logic           full_width,
  output logic           done
);
  localparam int CNT_LO  = STW + 3;
  localparam int SRC_BIT = CNT_LO + 5;
  localparam int DEC_BIT = SRC_BIT + 1;
  localparam int IDX_LO  = DEC_BIT + 1;
  localparam int CREG_LO = IDX_LO + RSW;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_DAT, S_FIN} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [DW-1:0] ir, ptr, left;

  wire           src_reg = ir[SRC_BIT];
  wire           dec     = ir[DEC_BIT];
  wire [RSW-1:0] idx_sel = ir[IDX_LO +: RSW];
  wire [RSW-1:0] cnt_sel = ir[CREG_LO +: RSW];
  wire [4:0]     imm     = ir[CNT_LO +: 5];
  wire [DW-1:0]  imm_cnt = (imm == 5'd0) ? DW'(32) : DW'(imm);
  wire           stall   = (st == S_DAT) && (ph == 2'd3) && !ready;

  assign rf_raddr   = (st == S_CMD && ph[1]) ? idx_sel : cnt_sel;
  assign bus_oe     = (st == S_CMD) || (st == S_ADR);
  assign alatch     = bus_oe;
  assign bus_out    = (st == S_CMD) ? {ir[DW-1:STW], cp_status} :
                      (st == S_ADR) ? {ptr[DW-1:STW], cp_status} : '0;
  assign phase      = ph;
  assign data_cyc   = (st == S_DAT);
  assign full_width = 1'b1;
  assign done       = (st == S_FIN);
  assign rf_we      = done;
  assign rf_waddr   = idx_sel;
  assign rf_wdata   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= 2'd0;
      ir   <= '0;
      ptr  <= '0;
      left <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ir <= instr;
          ph <= 2'd0;
          st <= S_CMD;
        end
        S_CMD: begin
          ph <= ph + 2'd1;
          if (ph == 2'd1) left <= src_reg ? rf_rdata : imm_cnt;
          if (ph == 2'd3) begin
            ptr <= (dec && left != '0) ? rf_rdata - DW'(STEP) : rf_rdata;
            st  <= (left == '0) ? S_FIN : S_ADR;
          end
        end
        S_ADR: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) st <= S_DAT;
        end
        S_DAT: begin
          if (!stall) ph <= ph + 2'd1;
          if (ph == 2'd3 && ready) begin
            left <= left - 1'b1;
            if (left == DW'(1)) begin
              st <= S_FIN;
              if (!dec) ptr <= ptr + DW'(STEP);
            end else begin
              ptr <= dec ? ptr - DW'(STEP) : ptr + DW'(STEP);
            end
          end
        end
        default: begin
          st <= S_IDLE;
          ph <= 2'd0;
        end
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (data_cyc && phase == 2'd3 && $stable(left)));

  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && phase == 2'd3 && ready) |=> (left == $past(left) - 1'b1));

  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(ir));

  a_r2_cmd_to_adr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && ph == 2'd3 && left != '0) |=> (st == S_ADR && ph == 2'd0));

  a_r6_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && ph == 2'd3 && left == '0) |=> done);
endmodule

// File: tb/copro_burst_seq_test.sv
`timescale 1ns/1ps
module copro_burst_seq_test;
  logic        clk = 0, rst_n = 0, start = 0, ready = 1;
  logic [31:0] instr = 0;
  logic [4:0]  cp_status = 0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, bus_out;
  logic        rf_we, bus_oe, alatch, data_cyc, full_width, done;
  logic [1:0]  phase;
  logic [31:0] rf [16];

  int vectors = 0, errs = 0;
  logic [31:0] cmd_word, adr_word;
  int nlatch, words, stalls, cycles, bad, narrow;

  always #2.5 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  copro_burst_seq uut (.clk, .rst_n, .start, .instr, .cp_status, .rf_raddr, .rf_rdata,
    .rf_we, .rf_waddr, .rf_wdata, .bus_out, .bus_oe, .alatch, .phase, .data_cyc,
    .ready, .full_width, .done);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] id, input logic [4:0] cnt, input bit src,
                                     input bit dec, input logic [3:0] idx, input logic [3:0] creg);
    return {9'h0A5, creg, idx, dec, src, cnt, id, 5'b0};
  endfunction

  task automatic run(input logic [31:0] ins, input bit stall_en, input bit poke);
    bit tog = 0;
    int k = 1;
    nlatch = 0; words = 0; stalls = 0; bad = 0; narrow = 0; cycles = 0;
    cmd_word = 0; adr_word = 0;
    @(negedge clk); instr = ins; start = 1;
    @(negedge clk); start = 0;
    forever begin
      ready = !(stall_en && tog); tog = ~tog;
      if (poke && k == 6) begin instr = mk(3'd1, 5'd9, 0, 0, 4'd1, 4'd0); start = 1; end
      else start = 0;
      if (!full_width) narrow++;
      if (alatch && phase == 2'd0) begin
        if (nlatch == 0) cmd_word = bus_out; else adr_word = bus_out;
        nlatch++;
      end
      if (data_cyc) begin
        if (bus_oe || alatch) bad++;
        if (phase == 2'd3 && ready) words++;
        if (phase == 2'd3 && !ready) stalls++;
      end
      if (done) begin cycles = k; break; end
      if (k > 3000) begin check(0, "R9 watchdog", k, 0); break; end
      k++;
      @(negedge clk);
    end
    ready = 1; start = 0;
    @(negedge clk);
    check(!done, "R9 done single cycle", done, 0);
  endtask

  task automatic t_reset;
    check(!done && !bus_oe && !alatch && !data_cyc, "R1 idle after reset",
          {done, bus_oe, alatch, data_cyc}, 0);
    check(full_width, "R11 width at reset", full_width, 1);
  endtask

  task automatic t_imm_up;
    logic [31:0] ins = mk(3'd3, 5'd5, 0, 0, 4'd2, 4'd0);
    rf[2] = 32'h0000_1000; cp_status = 5'h15;
    run(ins, 0, 0);
    check(cmd_word == {ins[31:5], 5'h15}, "R2 command word", cmd_word, {ins[31:5], 5'h15});
    check(adr_word == 32'h0000_1015, "R3 address word up", adr_word, 32'h0000_1015);
    check(words == 5, "R5 immediate count", words, 5);
    check(bad == 0, "R4 bus released in data", bad, 0);
    check(cycles == 29, "R9 done timing", cycles, 29);
    check(rf[2] == 32'h0000_10A0, "R7 up write-back", rf[2], 32'h0000_10A0);
    check(narrow == 0, "R11 width held", narrow, 0);
  endtask

  task automatic t_imm_zero;
    rf[4] = 32'h0000_0200; cp_status = 5'h03;
    run(mk(3'd2, 5'd0, 0, 0, 4'd4, 4'd0), 0, 0);
    check(words == 32, "R5 code 0 means 32", words, 32);
    check(cycles == 137, "R9 timing for 32 words", cycles, 137);
    check(rf[4] == 32'h0000_0600, "R7 write-back 32 words", rf[4], 32'h0000_0600);
  endtask

  task automatic t_reg_down;
    rf[6] = 3; rf[7] = 32'h0000_8000; cp_status = 5'h0A;
    run(mk(3'd5, 5'd17, 1, 1, 4'd7, 4'd6), 0, 0);
    check(words == 3, "R6 register count", words, 3);
    check(adr_word == 32'h0000_7FEA, "R3 address word down", adr_word, 32'h0000_7FEA);
    check(rf[7] == 32'h0000_7FA0, "R7 down write-back", rf[7], 32'h0000_7FA0);
  endtask

  task automatic t_reg_zero;
    rf[6] = 0; rf[7] = 32'h0000_4444;
    run(mk(3'd5, 5'd4, 1, 1, 4'd7, 4'd6), 0, 0);
    check(words == 0 && nlatch == 1, "R6 zero count skips cycles", {words[15:0], nlatch[15:0]}, 32'h0000_0001);
    check(cycles == 5, "R6 done after command", cycles, 5);
    check(rf[7] == 32'h0000_4444, "R6 index unchanged", rf[7], 32'h0000_4444);
  endtask

  task automatic t_stall;
    rf[3] = 32'h0000_0100;
    run(mk(3'd1, 5'd4, 0, 0, 4'd3, 4'd0), 1, 0);
    check(words == 4, "R8 stalls not counted", words, 4);
    check(stalls > 0, "R8 stalls seen", stalls, 1);
    check(cycles == 25 + stalls, "R8 held phases extend burst", cycles, 25 + stalls);
    check(rf[3] == 32'h0000_0180, "R8 write-back after stalls", rf[3], 32'h0000_0180);
  endtask

  task automatic t_busy_start;
    int extra = 0;
    rf[5] = 32'h0000_0040;
    run(mk(3'd4, 5'd2, 0, 0, 4'd5, 4'd0), 0, 1);
    check(words == 2, "R10 burst length kept", words, 2);
    repeat (20) begin
      @(negedge clk);
      if (alatch || done || data_cyc) extra++;
    end
    check(extra == 0, "R10 no second burst", extra, 0);
    check(rf[5] == 32'h0000_0080, "R10 write-back of first burst", rf[5], 32'h0000_0080);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_imm_up;
    t_imm_zero;
    t_reg_down;
    t_reg_zero;
    t_stall;
    t_busy_start;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #1000000;
    vectors++; errs++;
    $display("FAIL watchdog: got %h expected %h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule